// File: doc/BRIEF.md
# Two-Wire Debug Register Slave

A target-side serial slave for a two-wire debug link. The host drives a serial clock. The second wire is a shared data line with open-drain behaviour: any party may pull it low, and it floats high otherwise. A command opens with a START condition, which is a falling edge on the data line while the serial clock is high. The host then sends a 7-bit register address, most significant bit first, and a direction bit. After that, 8-bit data bytes move between the host and a small register space. Every byte is closed by a one-bit separator, during which the data line must be high.

The register space has two banks that share the same addresses. Reads return values from a read-only bank. Writes land in a separate write-only bank. Reading an address therefore never shows what was written to it. Address 0 of the read bank holds the product identification byte.

After each data byte the address steps forward, so a burst continues on the next register without a new address phase. A START placed in the separator ends the burst and begins a fresh command. Both serial wires are oversampled by the system clock through two-stage synchronisers. The system clock must run at least four times faster than the serial clock.

Top module: `twd_slave`

## Requirements
- R1: After reset the slave releases the data line (`sdaDrive` = 0), every write-only register reads 0 on `wrRegs`, and no command is active.
- R2: After a START, the slave samples 9 bits on rising serial-clock edges, in this order: 7 address bits MSB first, then the direction bit (0 = write, 1 = read), then the separator bit. Data bytes follow.
- R3: During a write, 8 data bits are taken MSB first. At the rising edge of the 8th bit the byte is committed to write-only register `addr`. That register occupies `wrRegs[addr*8 +: 8]`. A write to an address of `WR_REGS` or above changes nothing.
- R4: During a read, the slave drives the byte of read-only register `addr` MSB first. Each bit is placed after a falling serial-clock edge. The read value is the address zero-extended to 8 bits, XOR `RD_SEED` (default C3h), so address 00h returns the product ID C3h. A write to the same address does not alter what is read.
- R5: The rising edge of the separator after each data byte increments the address. The next byte in a burst, read or write, uses the following register.
- R6: An address increment from 7Fh wraps to 00h.
- R7: A START at any point aborts the current command, releases the line, and waits for a new address. A write byte interrupted before its 8th bit is not committed.
- R8: The slave pulls the data line only while sending read data bits. It never pulls the line during the address phase, during write bytes, or during any separator.
- R9: Clock activity before the first START is ignored. Nothing is committed and the line is never pulled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Serial clock from the host (asynchronous) |
| sdaIn | input | 1 | Sensed level of the shared data line (asynchronous) |
| sdaDrive | output | 1 | 1 = pull the data line low; 0 = release it |
| wrRegs | output | WR_REGS*DATA_W | Contents of the write-only bank, register n at bits n*DATA_W upward |

## Verification
The bench uses the defaults: `ADDR_W`=7, `DATA_W`=8, `WR_REGS`=4, `RD_SEED`=C3h, two synchroniser stages, and a serial half-period of 8 system clocks.
- With only four write-only registers, a write at address 04h exercises the dropped-write path (R3). A three-byte burst from 02h also runs past the last implemented register.
- The 7-bit address lets a two-byte read from 7Fh exercise the wrap to 00h (R6).
- The XOR seed gives every read address a distinct, predictable byte, so the bench can compute each expected read value on its own.

// File: rtl/twd_pkg.sv
package twd_pkg;

  // Command phase of the slave
  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ADDR,
    PH_DATA
  } phase_e;

  // Strobes from control to datapath, valid for a single system clock
  typedef struct packed {
    logic addrShift;   // shift a sampled address bit in
    logic dataShift;   // shift a sampled write bit in
    logic commit;      // store the completed write byte
    logic incAddr;     // step the register address
    logic loadRd;      // load read value and drive its MSB
    logic driveNext;   // drive the next read bit
    logic freeLine;    // release the data line
  } strobe_t;

endpackage

// File: rtl/twd_sync.sv
module twd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaBit,
  output logic sclRise,
  output logic sclFall,
  output logic startDet
);

  logic [STAGES-1:0] sclPipe, sdaPipe;
  logic sclPrev, sdaPrev, sclBit;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rstN) begin
          sclPipe <= '1;
          sdaPipe <= '1;
        end else begin
          sclPipe <= sclIn;
          sdaPipe <= sdaIn;
        end
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (!rstN) begin
          sclPipe <= '1;
          sdaPipe <= '1;
        end else begin
          sclPipe <= {sclPipe[STAGES-2:0], sclIn};
          sdaPipe <= {sdaPipe[STAGES-2:0], sdaIn};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclBit;
      sdaPrev <= sdaBit;
    end
  end

  assign sclBit   = sclPipe[STAGES-1];
  assign sdaBit   = sdaPipe[STAGES-1];
  assign sclRise  = sclBit & ~sclPrev;
  assign sclFall  = ~sclBit & sclPrev;
  assign startDet = sclBit & sclPrev & sdaPrev & ~sdaBit;

endmodule

// File: rtl/twd_ctrl.sv
module twd_ctrl
  import twd_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclRise,
  input  logic    sclFall,
  input  logic    startDet,
  input  logic    sdaBit,
  output strobe_t st,
  output logic    rdPhase,
  output logic    wrPhase
);

  localparam int MAX_IDX = (ADDR_W + 1 > DATA_W) ? ADDR_W + 1 : DATA_W;
  localparam int CNT_W   = $clog2(MAX_IDX + 1);
  localparam logic [CNT_W-1:0] RW_IDX   = CNT_W'(ADDR_W);
  localparam logic [CNT_W-1:0] ASEP_IDX = CNT_W'(ADDR_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] DSEP_IDX = CNT_W'(DATA_W);

  phase_e           phase;
  logic [CNT_W-1:0] bitCnt;
  logic             rwQ;

  always_comb begin
    st = '0;
    if (startDet) begin
      st.freeLine = 1'b1;
    end else begin
      unique case (phase)
        PH_ADDR: st.addrShift = sclRise && (bitCnt < RW_IDX);
        PH_DATA: begin
          if (sclRise && !rwQ && bitCnt < DSEP_IDX) st.dataShift = 1'b1;
          if (sclRise && !rwQ && bitCnt == LAST_BIT) st.commit = 1'b1;
          if (sclRise && bitCnt == DSEP_IDX) st.incAddr = 1'b1;
          if (sclFall && rwQ) begin
            if (bitCnt == '0) st.loadRd = 1'b1;
            else if (bitCnt < DSEP_IDX) st.driveNext = 1'b1;
            else st.freeLine = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      bitCnt <= '0;
      rwQ    <= 1'b0;
    end else if (startDet) begin
      phase  <= PH_ADDR;
      bitCnt <= '0;
      rwQ    <= 1'b0;
    end else if (sclRise) begin
      unique case (phase)
        PH_ADDR: begin
          if (bitCnt == RW_IDX) rwQ <= sdaBit;
          if (bitCnt == ASEP_IDX) begin
            phase  <= PH_DATA;
            bitCnt <= '0;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        PH_DATA: bitCnt <= (bitCnt == DSEP_IDX) ? '0 : bitCnt + 1'b1;
        default: ;
      endcase
    end
  end

  assign rdPhase = (phase == PH_DATA) && rwQ;
  assign wrPhase = (phase == PH_DATA) && !rwQ;

endmodule

// File: rtl/twd_dpath.sv
module twd_dpath
  import twd_pkg::*;
#(
  parameter int                ADDR_W  = 7,
  parameter int                DATA_W  = 8,
  parameter int                WR_REGS = 4,
  parameter logic [DATA_W-1:0] RD_SEED = 'hC3
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  strobe_t                   st,
  input  logic                      sdaBit,
  output logic                      sdaDrive,
  output logic [ADDR_W-1:0]         curAddr,
  output logic [WR_REGS*DATA_W-1:0] wrRegs
);

  logic [DATA_W-1:0]               shReg;
  logic [DATA_W-1:0]               rdVal;
  logic [DATA_W-1:0]               newByte;
  logic [WR_REGS-1:0]              hit;
  logic [WR_REGS-1:0][DATA_W-1:0]  bank;

  // Read-only bank: computed from the address
  assign rdVal   = DATA_W'(curAddr) ^ RD_SEED;
  assign newByte = {shReg[DATA_W-2:0], sdaBit};

  // Write-only bank decode, one comparator per implemented register
  for (genvar g = 0; g < WR_REGS; g++) begin : g_hit
    assign hit[g] = (curAddr == ADDR_W'(g));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr  <= '0;
      shReg    <= '0;
      sdaDrive <= 1'b0;
      bank     <= '0;
    end else begin
      if (st.addrShift) curAddr <= {curAddr[ADDR_W-2:0], sdaBit};
      if (st.incAddr)   curAddr <= curAddr + 1'b1;
      if (st.dataShift) shReg <= newByte;
      if (st.loadRd) begin
        shReg    <= rdVal;
        sdaDrive <= ~rdVal[DATA_W-1];
      end
      if (st.driveNext) begin
        shReg    <= shReg << 1;
        sdaDrive <= ~shReg[DATA_W-2];
      end
      if (st.freeLine) sdaDrive <= 1'b0;
      if (st.commit) begin
        for (int i = 0; i < WR_REGS; i++) begin
          if (hit[i]) bank[i] <= newByte;
        end
      end
    end
  end

  assign wrRegs = bank;

endmodule

// File: rtl/twd_slave.sv
module twd_slave
  import twd_pkg::*;
#(
  parameter int                ADDR_W      = 7,
  parameter int                DATA_W      = 8,
  parameter int                WR_REGS     = 4,
  parameter int                SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] RD_SEED     = 'hC3
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      sclIn,
  input  logic                      sdaIn,
  output logic                      sdaDrive,
  output logic [WR_REGS*DATA_W-1:0] wrRegs
);

  logic              sdaBit, sclRise, sclFall, startDet;
  logic              rdPhase, wrPhase;
  logic [ADDR_W-1:0] curAddr;
  strobe_t           st;

  twd_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk, .rstN, .sclIn, .sdaIn,
    .sdaBit, .sclRise, .sclFall, .startDet
  );

  twd_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) ctrl_i (
    .clk, .rstN, .sclRise, .sclFall, .startDet, .sdaBit,
    .st, .rdPhase, .wrPhase
  );

  twd_dpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WR_REGS(WR_REGS), .RD_SEED(RD_SEED)
  ) dpath_i (
    .clk, .rstN, .st, .sdaBit, .sdaDrive, .curAddr, .wrRegs
  );

endmodule

// File: rtl/twd_slave_chk.sv
module twd_slave_chk #(
  parameter int ADDR_W  = 7,
  parameter int DATA_W  = 8,
  parameter int WR_REGS = 4
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      sdaDrive,
  input logic [WR_REGS*DATA_W-1:0] wrRegs,
  input logic                      rdPhase,
  input logic                      wrPhase,
  input logic                      startDet,
  input logic                      sclRise,
  input logic [ADDR_W-1:0]         curAddr
);

  // R1
  reset_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |-> (!sdaDrive && wrRegs == '0));

  // R8
  drive_only_reading_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdPhase |-> !sdaDrive);

  // R3
  commit_in_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(wrRegs) |-> $past(wrPhase));

  // R7
  start_frees_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> !sdaDrive);

  // R5
  addr_moves_on_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(curAddr) |-> $past(sclRise));

endmodule

bind twd_slave twd_slave_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WR_REGS(WR_REGS)
) chk_i (
  .clk, .rstN, .sdaDrive, .wrRegs, .rdPhase, .wrPhase,
  .startDet, .sclRise, .curAddr
);

// File: tb/twd_slave_tb_top.sv
module twd_slave_tb_top;

  localparam time H = 80ns;
  localparam time Q = 40ns;
  localparam logic [7:0] SEED = 8'hC3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic hostLow = 1'b0;
  logic sdaLine;
  logic sdaDrive;
  logic [31:0] wrRegs;

  int checks = 0;
  int errors = 0;
  int badDrive = 0;
  bit hostWriting = 1'b0;
  bit finished = 1'b0;

  logic [7:0] expQ[$];
  logic [7:0] actQ[$];
  string      tagQ[$];

  always #5ns clk = ~clk;

  assign sdaLine = !(hostLow || sdaDrive);

  twd_slave dut_i (
    .clk, .rstN, .sclIn(scl), .sdaIn(sdaLine), .sdaDrive, .wrRegs
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] regOf(input int n);
    return wrRegs[n*8 +: 8];
  endfunction

  // Count any pull of the line while the host owns it (R8, R9)
  always @(negedge clk) if (hostWriting && sdaDrive) badDrive++;

  // Scoreboard monitor: pairs produced read bytes with expected ones
  initial begin
    forever begin
      @(negedge clk);
      while (actQ.size() > 0 && expQ.size() > 0) begin
        automatic logic [7:0] a = actQ.pop_front();
        automatic logic [7:0] e = expQ.pop_front();
        automatic string t = tagQ.pop_front();
        check(a == e, t, a, e);
      end
    end
  end

  task automatic sendBit(input bit b);
    hostLow = !b;
    #(H); scl = 1'b1;
    #(H); scl = 1'b0;
    #(Q);
  endtask

  task automatic readBit(output bit b);
    hostLow = 1'b0;
    #(H); b = sdaLine; scl = 1'b1;
    #(H); scl = 1'b0;
    #(Q);
  endtask

  task automatic startCond();
    hostLow = 1'b0;
    #(H); scl = 1'b1;
    #(H); hostLow = 1'b1;
    #(H); scl = 1'b0;
    #(Q);
  endtask

  task automatic sendAddr(input logic [6:0] a, input bit rd);
    hostWriting = 1'b1;
    startCond();
    for (int i = 6; i >= 0; i--) sendBit(a[i]);
    sendBit(rd);
    sendBit(1'b1);
    hostWriting = !rd;
  endtask

  task automatic writeByte(input logic [7:0] d);
    for (int i = 7; i >= 0; i--) sendBit(d[i]);
  endtask

  // Driver: pushes the expected byte, then clocks out the actual one
  task automatic readByte(input logic [7:0] exp, input string tag);
    logic [7:0] v;
    bit b;
    expQ.push_back(exp);
    tagQ.push_back(tag);
    for (int i = 7; i >= 0; i--) begin
      readBit(b);
      v[i] = b;
    end
    actQ.push_back(v);
  endtask

  task automatic readSep();
    bit b;
    readBit(b);
    check(b == 1'b1, "R8 separator released", b, 1);
  endtask

  task automatic endCmd();
    hostWriting = 1'b1;
    startCond();
    hostWriting = 1'b0;
  endtask

  initial begin
    #(3ms);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(sdaDrive == 1'b0, "R1 line released", sdaDrive, 0);
    check(wrRegs == 32'h0, "R1 bank cleared", wrRegs, 0);
    scl = 1'b0;
    #(H);

    // R9: traffic before any START is ignored
    hostWriting = 1'b1;
    for (int i = 0; i < 9; i++) sendBit(i[0]);
    writeByte(8'hFF);
    hostWriting = 1'b0;
    check(wrRegs == 32'h0, "R9 no commit before START", wrRegs, 0);

    // R2, R3: single write to address 01h
    sendAddr(7'h01, 1'b0);
    writeByte(8'hA5);
    endCmd();
    check(regOf(1) == 8'hA5, "R3 write reg1", regOf(1), 8'hA5);

    // R5: burst write from 02h into 02h, 03h, then 04h (dropped)
    sendAddr(7'h02, 1'b0);
    writeByte(8'h3C);
    sendBit(1'b1);
    writeByte(8'h7E);
    sendBit(1'b1);
    writeByte(8'h99);
    endCmd();
    check(regOf(2) == 8'h3C, "R5 burst reg2", regOf(2), 8'h3C);
    check(regOf(3) == 8'h7E, "R5 burst reg3", regOf(3), 8'h7E);
    check(regOf(0) == 8'h00 && regOf(1) == 8'hA5, "R3 out of range drop",
          {regOf(1), regOf(0)}, 16'hA500);

    // R4: separate banks at address 0
    sendAddr(7'h00, 1'b0);
    writeByte(8'h5A);
    endCmd();
    check(regOf(0) == 8'h5A, "R3 write reg0", regOf(0), 8'h5A);
    sendAddr(7'h00, 1'b1);
    readByte(SEED, "R4 product id after write");
    endCmd();

    // R4, R5: read burst from 05h
    sendAddr(7'h05, 1'b1);
    readByte(8'h05 ^ SEED, "R4 read 05h");
    readSep();
    readByte(8'h06 ^ SEED, "R5 read burst 06h");
    readSep();
    readByte(8'h07 ^ SEED, "R5 read burst 07h");
    endCmd();

    // R6: address wrap 7Fh -> 00h
    sendAddr(7'h7F, 1'b1);
    readByte(8'h7F ^ SEED, "R6 read 7Fh");
    readSep();
    readByte(8'h00 ^ SEED, "R6 wrap to 00h");
    endCmd();

    // R3: write beyond implemented registers changes nothing
    sendAddr(7'h04, 1'b0);
    writeByte(8'hFF);
    endCmd();
    check(wrRegs == {8'h7E, 8'h3C, 8'hA5, 8'h5A}, "R3 addr 04h ignored",
          wrRegs, {8'h7E, 8'h3C, 8'hA5, 8'h5A});

    // R7: START in the middle of a write byte aborts without commit
    sendAddr(7'h01, 1'b0);
    sendBit(1'b0); sendBit(1'b1); sendBit(1'b1); sendBit(1'b0);
    sendAddr(7'h03, 1'b0);
    writeByte(8'h11);
    endCmd();
    check(regOf(1) == 8'hA5, "R7 aborted byte not committed", regOf(1), 8'hA5);
    check(regOf(3) == 8'h11, "R7 new command after abort", regOf(3), 8'h11);

    // R7: START during a read separator aborts the read
    sendAddr(7'h10, 1'b1);
    readByte(8'h10 ^ SEED, "R7 read before abort");
    endCmd();
    #(H);
    check(sdaDrive == 1'b0, "R7 line released after abort", sdaDrive, 0);

    // R8: line never pulled while the host was sending
    check(badDrive == 0, "R8 no drive during host bits", badDrive, 0);

    repeat (20) @(negedge clk);
    check(expQ.size() == 0, "R4 scoreboard drained", expQ.size(), 0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule